// File: doc/BRIEF.md
# Section Translation Walker with Access Checking

This block maps a 32-bit virtual address to a physical address through a single-level translation table. Each table entry is one 32-bit word and maps a 1 MB section. On a request, the block first latches the virtual address and its access context. The context is the table base, the domain access word, the two global protection bits, the privilege level and the read/write direction. The block then fetches the table entry with one word read on a simple request/valid memory port.

The fetched entry is decoded and judged in the same cycle that the read data arrives. The block first checks that the entry marks a section. It then looks up the access mode of the entry's domain and applies the access-permission rules. One cycle later it reports the result: either a physical address with its cacheable and bufferable attributes, or a fault code.

The block handles one walk at a time. A surrounding load/store unit raises a request and waits for the single-cycle completion pulse. It does not need to hold its inputs steady after the request is accepted.

Top module: `sect_xlate`

## Requirements
- R1: While reset is held, and after it is released with no request, `done` and `mem_rd_req` are low.
- R2: After a request is accepted, `mem_rd_req` stays high with `mem_rd_addr = {ttb[31:14], va[31:20], 2'b00}` until `mem_rd_valid` is seen. The low 14 table-base bits never reach the address.
- R3: For a walk without fault, `pa = {entry[31:20], va[19:0]}` and `fault` is 2'b00.
- R4: An entry whose bits [1:0] are not 2'b10 gives `fault` = 2'b01 (translation). This takes priority over domain and permission checks.
- R5: The domain number is entry bits [8:5]. The mode is read from `dac[2d+1:2d]`. Modes 2'b00 and 2'b10 give `fault` = 2'b10 (domain).
- R6: Domain mode 2'b11 grants any access regardless of the AP bits (entry [11:10]) and the protection bits.
- R7: In domain mode 2'b01, the AP bits decide the access. AP 2'b01 allows privileged read/write and no user access. AP 2'b10 allows privileged read/write and user read only. AP 2'b11 allows all accesses. A denied access gives `fault` = 2'b11 (permission).
- R8: In domain mode 2'b01 with AP 2'b00, the protection bits decide the access:
  - `sys_prot`=0 and `rom_prot`=0 deny every access.
  - `sys_prot`=1 and `rom_prot`=0 allow privileged reads only.
  - `sys_prot`=0 and `rom_prot`=1 allow reads at either level.
  - Both bits set deny every access.
- R9: `done` is high for exactly one cycle per walk. It rises one cycle after the edge that sees `mem_rd_valid`. When `fault` is not 2'b00, `pa`, `attr_c` and `attr_b` are zero.
- R10: A request raised while a walk is in progress is ignored. The walk completes with the context latched at acceptance, even if the context inputs change mid-walk.
- R11: The read may take any number of cycles. `done` stays low while `mem_rd_valid` is low.
- R12: For a walk without fault, `attr_c` equals entry bit 3 and `attr_b` equals entry bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request, accepted when idle |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_priv | input | 1 | 1 = privileged access, 0 = user |
| ttb | input | 32 | Translation table base (low 14 bits ignored) |
| dac | input | 32 | Domain access word, two bits per domain |
| sys_prot | input | 1 | System protection bit |
| rom_prot | input | 1 | ROM protection bit |
| mem_rd_req | output | 1 | Table read request |
| mem_rd_addr | output | 32 | Table entry word address |
| mem_rd_valid | input | 1 | Table read data valid |
| mem_rd_data | input | 32 | Table entry |
| done | output | 1 | One-cycle completion pulse |
| pa | output | 32 | Physical address |
| attr_c | output | 1 | Cacheable attribute |
| attr_b | output | 1 | Bufferable attribute |
| fault | output | 2 | 00 none, 01 translation, 10 domain, 11 permission |

## Verification
The hardest case to reach is a mid-walk change of context: a second request and new table base, domain word and protection bits that all arrive while the read is still outstanding. The stimulus reaches it by stretching the read latency and, in the middle of that window, raising the request again with fresh random context. It then checks that the read address holds and that the result matches the original context. The permission matrix is covered by directed walks for every combination of AP bits and protection bits at both privilege levels and both directions. Random walks then mix domain words, entry types and latencies.

// File: rtl/sxl_pkg.sv
package sxl_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_XLATE  = 2'b01,
    FLT_DOMAIN = 2'b10,
    FLT_PERM   = 2'b11
  } fault_e;

  typedef enum logic [1:0] {
    DM_NOACC   = 2'b00,
    DM_CLIENT  = 2'b01,
    DM_RSVD    = 2'b10,
    DM_MANAGER = 2'b11
  } dmode_e;

  typedef enum logic [1:0] {
    AP_PROT = 2'b00,
    AP_PRIV = 2'b01,
    AP_UREAD = 2'b10,
    AP_FULL = 2'b11
  } ap_e;

  localparam logic [1:0] SECTION_TAG = 2'b10;
endpackage

// File: rtl/sxl_desc_decode.sv
module sxl_desc_decode #(
  parameter int ADDR_W     = 32,
  parameter int SECT_SHIFT = 20,
  parameter int DOM_W      = 4
) (
  input  logic [ADDR_W-1:0]            desc,
  output logic                         is_section,
  output logic [ADDR_W-SECT_SHIFT-1:0] sect_base,
  output logic [1:0]                   ap,
  output logic [DOM_W-1:0]             dom,
  output logic                         cbit,
  output logic                         bbit
);
  import sxl_pkg::*;

  localparam int DOM_LO = 5;
  localparam int AP_LO  = 10;

  always_comb begin
    is_section = (desc[1:0] == SECTION_TAG);
    sect_base  = desc[ADDR_W-1:SECT_SHIFT];
    ap         = desc[AP_LO+1:AP_LO];
    dom        = desc[DOM_LO+DOM_W-1:DOM_LO];
    cbit       = desc[3];
    bbit       = desc[2];
  end
endmodule

// File: rtl/sxl_access_check.sv
module sxl_access_check #(
  parameter int DOM_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              ap,
  input  logic [DOM_W-1:0]        dom,
  input  logic [2*(1<<DOM_W)-1:0] dac,
  input  logic                    sys_prot,
  input  logic                    rom_prot,
  input  logic                    priv,
  input  logic                    write,
  output sxl_pkg::fault_e         flt
);
  import sxl_pkg::*;

  localparam int NDOM = 1 << DOM_W;

  logic [1:0] mode_tab [NDOM];
  logic [1:0] mode;
  logic       ap_ok;

  for (genvar g = 0; g < NDOM; g++) begin : g_mode
    assign mode_tab[g] = dac[2*g+1:2*g];
  end

  assign mode = mode_tab[dom];

  always_comb begin
    ap_ok = 1'b0;
    unique case (ap_e'(ap))
      AP_PROT: begin
        unique case ({sys_prot, rom_prot})
          2'b10:   ap_ok = priv & ~write;
          2'b01:   ap_ok = ~write;
          default: ap_ok = 1'b0;
        endcase
      end
      AP_PRIV:  ap_ok = priv;
      AP_UREAD: ap_ok = priv | ~write;
      AP_FULL:  ap_ok = 1'b1;
      default:  ap_ok = 1'b0;
    endcase
  end

  always_comb begin
    unique case (dmode_e'(mode))
      DM_MANAGER: flt = FLT_NONE;
      DM_CLIENT:  flt = ap_ok ? FLT_NONE : FLT_PERM;
      default:    flt = FLT_DOMAIN;
    endcase
  end

  // R6: manager domains never yield a permission fault
  p_manager_no_perm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |-> (flt == FLT_NONE));
  // R7: full access AP never denies a client
  p_full_ap_grants_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && ap == 2'b11) |-> (flt == FLT_NONE));
endmodule

// File: rtl/sxl_walk_ctl.sv
module sxl_walk_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic rd_valid,
  output logic accept,
  output logic waiting,
  output logic capture
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;

  st_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    accept  = 1'b0;
    capture = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        accept = 1'b1;
        st_d   = ST_WAIT;
      end
      ST_WAIT: if (rd_valid) begin
        capture = 1'b1;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign waiting = (st_q == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // R11: an outstanding read keeps the walker waiting
  p_wait_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !rd_valid) |=> waiting);
  // R10: no acceptance while a walk is outstanding
  p_no_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !accept);
endmodule

// File: rtl/sect_xlate.sv
module sect_xlate #(
  parameter int ADDR_W     = 32,
  parameter int SECT_SHIFT = 20,
  parameter int DOM_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_va,
  input  logic              req_write,
  input  logic              req_priv,
  input  logic [ADDR_W-1:0] ttb,
  input  logic [2*(1<<DOM_W)-1:0] dac,
  input  logic              sys_prot,
  input  logic              rom_prot,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [ADDR_W-1:0] mem_rd_data,
  output logic              done,
  output logic [ADDR_W-1:0] pa,
  output logic              attr_c,
  output logic              attr_b,
  output logic [1:0]        fault
);
  import sxl_pkg::*;

  localparam int IDX_W   = ADDR_W - SECT_SHIFT;
  localparam int TTB_LOW = IDX_W + 2;
  localparam int DAC_W   = 2 * (1 << DOM_W);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic accept, waiting, capture;

  sxl_walk_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .req_valid(req_valid),
    .rd_valid (mem_rd_valid),
    .accept   (accept),
    .waiting  (waiting),
    .capture  (capture)
  );

  // context captured at acceptance
  logic [ADDR_W-1:0]      va_q, va_d;
  logic [ADDR_W-TTB_LOW-1:0] tb_q, tb_d;
  logic [DAC_W-1:0]       dac_q, dac_d;
  logic                   sys_q, sys_d, rom_q, rom_d, priv_q, priv_d, wr_q, wr_d;

  always_comb begin
    va_d   = va_q;   tb_d  = tb_q;  dac_d = dac_q;
    sys_d  = sys_q;  rom_d = rom_q; priv_d = priv_q; wr_d = wr_q;
    if (accept) begin
      va_d   = req_va;
      tb_d   = ttb[ADDR_W-1:TTB_LOW];
      dac_d  = dac;
      sys_d  = sys_prot;
      rom_d  = rom_prot;
      priv_d = req_priv;
      wr_d   = req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      va_q <= '0; tb_q <= '0; dac_q <= '0;
      sys_q <= 1'b0; rom_q <= 1'b0; priv_q <= 1'b0; wr_q <= 1'b0;
    end else begin
      va_q <= va_d; tb_q <= tb_d; dac_q <= dac_d;
      sys_q <= sys_d; rom_q <= rom_d; priv_q <= priv_d; wr_q <= wr_d;
    end
  end

  assign mem_rd_req  = waiting;
  assign mem_rd_addr = {tb_q, va_q[ADDR_W-1:SECT_SHIFT], 2'b00};

  // entry decode and access judgement
  logic             is_sect, cb_c, cb_b;
  logic [IDX_W-1:0] sect_base;
  logic [1:0]       ap;
  logic [DOM_W-1:0] dom;
  fault_e           acc_flt, res_flt;

  sxl_desc_decode #(.ADDR_W(ADDR_W), .SECT_SHIFT(SECT_SHIFT), .DOM_W(DOM_W)) u_dec (
    .desc      (mem_rd_data),
    .is_section(is_sect),
    .sect_base (sect_base),
    .ap        (ap),
    .dom       (dom),
    .cbit      (cb_c),
    .bbit      (cb_b)
  );

  sxl_access_check #(.DOM_W(DOM_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .ap      (ap),
    .dom     (dom),
    .dac     (dac_q),
    .sys_prot(sys_q),
    .rom_prot(rom_q),
    .priv    (priv_q),
    .write   (wr_q),
    .flt     (acc_flt)
  );

  assign res_flt = is_sect ? acc_flt : FLT_XLATE;

  // result registers
  logic              done_q, done_d;
  logic [ADDR_W-1:0] pa_q, pa_d;
  logic              c_q, c_d, b_q, b_d;
  logic [1:0]        flt_q, flt_d;

  always_comb begin
    done_d = capture;
    pa_d   = pa_q;
    c_d    = c_q;
    b_d    = b_q;
    flt_d  = flt_q;
    if (capture) begin
      flt_d = res_flt;
      if (res_flt == FLT_NONE) begin
        pa_d = {sect_base, va_q[SECT_SHIFT-1:0]};
        c_d  = cb_c;
        b_d  = cb_b;
      end else begin
        pa_d = '0;
        c_d  = 1'b0;
        b_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      done_q <= 1'b0; pa_q <= '0; c_q <= 1'b0; b_q <= 1'b0; flt_q <= '0;
    end else begin
      done_q <= done_d; pa_q <= pa_d; c_q <= c_d; b_q <= b_d; flt_q <= flt_d;
    end
  end

  assign done   = done_q;
  assign pa     = pa_q;
  assign attr_c = c_q;
  assign attr_b = b_q;
  assign fault  = flt_q;

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |=> !done);
  // R9: faults carry no address or attributes
  p_fault_clears_pa_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (done && fault != 2'b00) |-> (pa == '0 && !attr_c && !attr_b));
  // R2: read request and address hold until data returns
  p_rd_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));
  // R3: section offset passes through
  p_pa_offset_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (done && fault == 2'b00) |-> (pa[SECT_SHIFT-1:0] == va_q[SECT_SHIFT-1:0]));
  // R11: no completion without returned data
  p_done_needs_data_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mem_rd_req && !mem_rd_valid) |=> !done);
endmodule

// File: tb/sim_sect_xlate.sv
module sim_sect_xlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_priv, sys_prot, rom_prot;
  logic [31:0] req_va, ttb, dac;
  logic        mem_rd_req, mem_rd_valid;
  logic [31:0] mem_rd_addr, mem_rd_data;
  logic        done, attr_c, attr_b;
  logic [31:0] pa;
  logic [1:0]  fault;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  sect_xlate u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_write(req_write), .req_priv(req_priv), .ttb(ttb), .dac(dac),
    .sys_prot(sys_prot), .rom_prot(rom_prot), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .done(done), .pa(pa), .attr_c(attr_c),
    .attr_b(attr_b), .fault(fault)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkdesc(input logic [11:0] base, input logic [1:0] ap,
      input logic [3:0] dom, input bit c, input bit b, input logic [1:0] lo);
    return {base, 8'h00, ap, 1'b0, dom, 1'b1, c, b, lo};
  endfunction

  function automatic bit allowed(input logic [1:0] ap, input bit s, input bit r,
                                 input bit pv, input bit wr);
    case (ap)
      2'b00: begin
        if (s && !r) return pv && !wr;
        if (!s && r) return !wr;
        return 1'b0;
      end
      2'b01:   return pv;
      2'b10:   return pv || !wr;
      default: return 1'b1;
    endcase
  endfunction

  // returns {fault, c, b, pa}
  function automatic logic [35:0] expect_res(input logic [31:0] va, input logic [31:0] dc,
      input bit s, input bit r, input bit pv, input bit wr, input logic [31:0] d);
    logic [1:0] m;
    logic [1:0] f;
    if (d[1:0] != 2'b10) return {2'b01, 2'b00, 32'h0};
    m = dc[2*d[8:5] +: 2];
    if (m == 2'b00 || m == 2'b10) f = 2'b10;
    else if (m == 2'b11) f = 2'b00;
    else f = allowed(d[11:10], s, r, pv, wr) ? 2'b00 : 2'b11;
    if (f != 2'b00) return {f, 2'b00, 32'h0};
    return {2'b00, d[3], d[2], d[31:20], va[19:0]};
  endfunction

  task automatic walk(input logic [31:0] va, input logic [31:0] tb_i, input logic [31:0] dc,
      input bit s, input bit r, input bit pv, input bit wr, input logic [31:0] d,
      input int lat, input bit disturb, input string tag);
    logic [35:0] e;
    logic [31:0] ea;
    e  = expect_res(va, dc, s, r, pv, wr, d);
    ea = {tb_i[31:14], va[31:20], 2'b00};
    @(negedge clk);
    req_va = va; ttb = tb_i; dac = dc; sys_prot = s; rom_prot = r;
    req_priv = pv; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_rd_req == 1'b1, "R2", "rd_req after accept", 64'(mem_rd_req), 64'd1);
    chk(mem_rd_addr == ea, "R2", "table address", 64'(mem_rd_addr), 64'(ea));
    if (disturb) begin
      req_va = $urandom; ttb = $urandom; dac = $urandom;
      sys_prot = ~s; rom_prot = ~r; req_priv = ~pv; req_write = ~wr;
      req_valid = 1'b1;
    end
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk(done == 1'b0 && mem_rd_req == 1'b1, "R11", "waiting for data",
          64'({done, mem_rd_req}), 64'b01);
      if (disturb)
        chk(mem_rd_addr == ea, "R10", "address held under new request",
            64'(mem_rd_addr), 64'(ea));
    end
    mem_rd_valid = 1'b1;
    mem_rd_data  = d;
    @(negedge clk);
    mem_rd_valid = 1'b0;
    mem_rd_data  = $urandom;
    req_valid    = 1'b0;
    chk(done == 1'b1, tag, "done pulse", 64'(done), 64'd1);
    chk({fault, attr_c, attr_b, pa} == e, tag, "{fault,c,b,pa}",
        64'({fault, attr_c, attr_b, pa}), 64'(e));
    @(negedge clk);
    chk(done == 1'b0 && mem_rd_req == 1'b0, "R9", "single done, idle after",
        64'({done, mem_rd_req}), 64'b00);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; req_valid = 1'b1; req_va = 32'h1234_5678; req_write = 1'b0;
    req_priv = 1'b1; ttb = 32'h0; dac = 32'hFFFF_FFFF; sys_prot = 1'b0;
    rom_prot = 1'b0; mem_rd_valid = 1'b0; mem_rd_data = 32'h0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && mem_rd_req == 1'b0, "R1", "in reset", 64'({done, mem_rd_req}), 64'b00);
    req_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done == 1'b0 && mem_rd_req == 1'b0, "R1", "after reset", 64'({done, mem_rd_req}), 64'b00);

    // R2/R3/R12: plain translations with varied attributes and an unaligned base
    walk(32'hABC1_2345, 32'h008F_3FFF, 32'hFFFF_FFFF, 0, 0, 1, 1,
         mkdesc(12'h300, 2'b11, 4'd0, 1, 1, 2'b10), 0, 0, "R3");
    walk(32'h0007_FFFF, 32'h3160_0000, 32'h0000_0001, 0, 0, 0, 0,
         mkdesc(12'hFFF, 2'b11, 4'd0, 1, 0, 2'b10), 1, 0, "R12");
    walk(32'hFFFF_FFFF, 32'hFFFF_C000, 32'h0000_0004, 0, 0, 0, 1,
         mkdesc(12'h001, 2'b11, 4'd1, 0, 1, 2'b10), 2, 0, "R12");
    // R4: non-section entries, even with a manager domain
    walk(32'h0010_0000, 32'h0, 32'hFFFF_FFFF, 0, 0, 1, 0,
         mkdesc(12'h100, 2'b11, 4'd0, 1, 1, 2'b00), 0, 0, "R4");
    walk(32'h0020_0000, 32'h0, 32'hFFFF_FFFF, 0, 0, 1, 0,
         mkdesc(12'h100, 2'b11, 4'd0, 1, 1, 2'b01), 1, 0, "R4");
    walk(32'h0030_0000, 32'h0, 32'hFFFF_FFFF, 0, 0, 1, 0,
         mkdesc(12'h100, 2'b11, 4'd0, 1, 1, 2'b11), 0, 0, "R4");
    // R5: domain 15 no-access and domain 7 reserved
    walk(32'h4000_0000, 32'h0, 32'h3FFF_FFFF, 0, 0, 1, 0,
         mkdesc(12'h400, 2'b11, 4'd15, 1, 1, 2'b10), 0, 0, "R5");
    walk(32'h4000_0000, 32'h0, 32'hFFFF_BFFF, 0, 0, 1, 0,
         mkdesc(12'h400, 2'b11, 4'd7, 1, 1, 2'b10), 0, 0, "R5");
    // R6: manager overrides the AP bits and protection bits
    walk(32'h5555_0000, 32'h0, 32'h0000_0C00, 0, 0, 0, 1,
         mkdesc(12'h555, 2'b00, 4'd5, 1, 1, 2'b10), 0, 0, "R6");
    walk(32'h5555_0000, 32'h0, 32'h0000_0C00, 1, 1, 0, 1,
         mkdesc(12'h555, 2'b01, 4'd5, 0, 0, 2'b10), 0, 0, "R6");
    // R7/R8: full client matrix in domain 2
    for (int ap = 0; ap < 4; ap++)
      for (int sr = 0; sr < 4; sr++)
        for (int pw = 0; pw < 4; pw++)
          walk(32'h2000_0000 | (32'(pw) << 4), 32'h0, 32'h0000_0010,
               sr[1], sr[0], pw[1], pw[0],
               mkdesc(12'h200, 2'(ap), 4'd2, 1, 0, 2'b10), 0, 0,
               (ap == 0) ? "R8" : "R7");
    // R10: new request and new context during a long read
    walk(32'h8123_4567, 32'h0040_0000, 32'h0000_0001, 1, 0, 1, 0,
         mkdesc(12'h812, 2'b00, 4'd0, 1, 1, 2'b10), 5, 1, "R10");
    walk(32'h9000_0001, 32'h0080_0000, 32'h0000_0001, 0, 0, 0, 1,
         mkdesc(12'h900, 2'b10, 4'd0, 0, 1, 2'b10), 4, 1, "R10");
    // R11: long latency
    walk(32'h0ABC_DEF0, 32'h1000_0000, 32'hFFFF_FFFF, 0, 0, 1, 1,
         mkdesc(12'h0AB, 2'b11, 4'd3, 1, 1, 2'b10), 40, 0, "R11");

    // random walks
    for (int n = 0; n < 300; n++) begin
      logic [31:0] d;
      logic [1:0]  lo;
      lo = ($urandom % 5 == 0) ? 2'($urandom) : 2'b10;
      d  = mkdesc(12'($urandom), 2'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), lo);
      walk($urandom, $urandom, $urandom, 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), d, int'($urandom % 4), 1'($urandom % 6 == 0), "R3");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule